// File: doc/BRIEF.md
# Up-Counting Overflow Interval Timer

This block is a free-running interval timer whose counter climbs from a programmed start value and raises an overflow event when it steps past the all-ones value. Software sets up an interval of N+1 clock cycles by writing the all-ones value minus N as the start count. The timer can then stop after the first overflow (one-shot) or restart from a separately held load value on every overflow (periodic).

Software reaches the timer through a plain write port and a combinational read port. Every write is posted: it enters a short fixed-length pipeline and changes the addressed register a fixed number of clocks later. A pending flag stays high while any write is still in that pipeline. The overflow status bit is sticky and is cleared by writing a one to it. The interrupt line is that status bit gated by an enable bit.

Register map (word addresses on `wr_addr` and `rd_addr`):
- 0 control: bit 0 run, bit 1 auto-reload.
- 1 load value.
- 2 counter: reads the live count, and a write replaces it.
- 3 status: bit 0 overflow flag, write 1 to clear.
- 4 interrupt enable: bit 0.
- 5 load-and-start: write only, reads as 0.

Top module: `up_timer`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `wr_pending` is 0.
- R2: While the run bit (control bit 0) is 1, the counter rises by one on every clock. While the run bit is 0, the counter holds its value.
- R3: The overflow flag (status bit 0) is set on the clock edge at which a running counter steps from all-ones. With a start value of all-ones minus N, that edge comes N+1 edges after the start takes effect.
- R4: With auto-reload (control bit 1) clear, an overflow leaves the counter at 0 and the run bit cleared, and the counter then stays at 0.
- R5: With auto-reload set, an overflow loads the counter from the load register (address 1), so overflows repeat every N+1 clocks.
- R6: Writing a value with bit 0 set to the status register (address 3) clears the flag. Writing 0 to it has no effect. An overflow on the same edge as a clear wins.
- R7: `irq` equals the overflow flag AND interrupt enable bit 0 (address 4), and holds as a level until the flag is cleared.
- R8: A bus write changes its register on the second rising edge after the edge that samples it. `wr_pending` is high from the sampling edge until that write has been applied.
- R9: A write to address 5 puts its data into the counter and sets the run bit, leaving auto-reload unchanged. A write to the load register alone changes neither the counter nor the run bit.
- R10: Reading the counter (address 2) returns the live count and does not disturb counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr | input | AW | Write register address |
| wr_data | input | WIDTH | Write data |
| rd_addr | input | AW | Read register address |
| rd_data | output | WIDTH | Combinational read data |
| irq | output | 1 | Overflow interrupt level |
| wr_pending | output | 1 | High while a posted write is in flight |

## Verification
Every write result is due two edges after the edge that samples the write. The bench therefore waits two falling edges after each write before it reads back, and it samples `wr_pending` and the old value at the falling edges in between. For an interval of N, the start takes effect two edges after the load-and-start write, and the overflow lands N+1 edges after that. The bench counts falling edges from the write and checks the flag clear at edge N+2 and set at edge N+3. It then checks the counter at N+3, where it has reloaded or stopped, and again at 2N+4 for the periodic case. All inputs change on falling edges and every output is read 1 ns later, so no result depends on the order of processes at a clock edge.

// File: rtl/up_timer.sv
module up_timer #(
  parameter int WIDTH      = 32,
  parameter int AW         = 3,
  parameter int POST_DELAY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  output logic             irq,
  output logic             wr_pending
);

  localparam logic [AW-1:0] A_CTRL   = AW'(0);
  localparam logic [AW-1:0] A_LOAD   = AW'(1);
  localparam logic [AW-1:0] A_COUNT  = AW'(2);
  localparam logic [AW-1:0] A_STAT   = AW'(3);
  localparam logic [AW-1:0] A_IEN    = AW'(4);
  localparam logic [AW-1:0] A_LSTART = AW'(5);
  localparam int LAST = POST_DELAY - 1;

  logic [POST_DELAY-1:0] pv;
  logic [AW-1:0]         pa [POST_DELAY];
  logic [WIDTH-1:0]      pd [POST_DELAY];

  logic [WIDTH-1:0] count_q, load_q;
  logic run_q, reload_q, status_q, ien_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv <= '0;
      for (int i = 0; i < POST_DELAY; i++) begin
        pa[i] <= '0;
        pd[i] <= '0;
      end
    end else begin
      pv[0] <= wr_en;
      pa[0] <= wr_addr;
      pd[0] <= wr_data;
      for (int i = 1; i < POST_DELAY; i++) begin
        pv[i] <= pv[i-1];
        pa[i] <= pa[i-1];
        pd[i] <= pd[i-1];
      end
    end
  end

  wire             ap_v = pv[LAST];
  wire [AW-1:0]    ap_a = pa[LAST];
  wire [WIDTH-1:0] ap_d = pd[LAST];

  wire w_ctrl   = ap_v && ap_a == A_CTRL;
  wire w_load   = ap_v && ap_a == A_LOAD;
  wire w_count  = ap_v && ap_a == A_COUNT;
  wire w_stat   = ap_v && ap_a == A_STAT;
  wire w_ien    = ap_v && ap_a == A_IEN;
  wire w_lstart = ap_v && ap_a == A_LSTART;

  wire top_ones = &count_q;
  wire tick     = run_q && top_ones;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '0;
      load_q   <= '0;
      run_q    <= 1'b0;
      reload_q <= 1'b0;
      status_q <= 1'b0;
      ien_q    <= 1'b0;
    end else begin
      if (w_count || w_lstart)
        count_q <= ap_d;
      else if (run_q)
        count_q <= top_ones ? (reload_q ? load_q : '0) : count_q + 1'b1;

      if (w_ctrl)
        run_q <= ap_d[0];
      else if (w_lstart)
        run_q <= 1'b1;
      else if (tick && !reload_q)
        run_q <= 1'b0;

      if (w_ctrl) reload_q <= ap_d[1];
      if (w_load) load_q   <= ap_d;
      if (w_ien)  ien_q    <= ap_d[0];

      if (tick)
        status_q <= 1'b1;
      else if (w_stat && ap_d[0])
        status_q <= 1'b0;
    end
  end

  assign irq        = status_q & ien_q;
  assign wr_pending = |pv;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data = {{(WIDTH-2){1'b0}}, reload_q, run_q};
      A_LOAD:  rd_data = load_q;
      A_COUNT: rd_data = count_q;
      A_STAT:  rd_data = {{(WIDTH-1){1'b0}}, status_q};
      A_IEN:   rd_data = {{(WIDTH-1){1'b0}}, ien_q};
      default: rd_data = '0;
    endcase
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !ap_v |=> $stable(count_q)); // R2
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && !top_ones && !ap_v |=> count_q == $past(count_q) + 1'b1); // R2
  AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> status_q); // R3
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !reload_q && !ap_v |=> !run_q && count_q == '0); // R4
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tick && reload_q && !ap_v |=> count_q == $past(load_q)); // R5
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    w_stat && ap_d[0] && !tick |=> !status_q); // R6
  AST_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> wr_pending); // R8

endmodule

// File: tb/up_timer_test.sv
module up_timer_test;
  localparam int W = 32;
  localparam logic [2:0] A_CTRL = 3'd0, A_LOAD = 3'd1, A_COUNT = 3'd2,
                         A_STAT = 3'd3, A_IEN = 3'd4, A_LSTART = 3'd5;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [W-1:0] wr_data = '0, rd_data;
  logic irq, wr_pending;
  int checks = 0, failures = 0;

  up_timer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
    .wr_pending(wr_pending));

  always #10 clk = ~clk;

  function automatic int ovf_edge(input int n); return n + 3; endfunction
  function automatic int period(input int n);   return n + 1; endfunction
  function automatic logic [W-1:0] start_val(input int n); return ~W'(n); endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic settle; repeat (2) @(negedge clk); endtask

  task automatic interval(input int n, input bit periodic, input bit ien);
    logic [W-1:0] v;
    logic [W-1:0] l = start_val(n);
    wr(A_CTRL, 0); settle;
    wr(A_STAT, 1); settle;
    wr(A_CTRL, periodic ? 2 : 0); settle;
    wr(A_LOAD, l);
    wr(A_LSTART, l);
    for (int j = 1; j <= ovf_edge(n); j++) begin
      @(negedge clk);
      if (j == 2) begin rd(A_COUNT, v); chk("R9 start count", v, l); end
      if (j == 3) begin rd(A_COUNT, v); chk("R2 increment", v, l + 1); end
      if (j == ovf_edge(n) - 1) begin rd(A_STAT, v); chk("R3 flag early", v, 0); end
    end
    rd(A_STAT, v); chk("R3 flag at overflow", v, 1);
    chk("R7 irq", W'(irq), W'(ien));
    rd(A_COUNT, v);
    if (periodic) begin
      chk("R5 reload", v, l);
      repeat (period(n)) @(negedge clk);
      rd(A_COUNT, v); chk("R5 second period", v, l);
    end else begin
      chk("R4 stop at zero", v, 0);
      rd(A_CTRL, v); chk("R4 run cleared", v & 1, 0);
      repeat (3) @(negedge clk);
      rd(A_COUNT, v); chk("R4 stays zero", v, 0);
    end
    wr(A_CTRL, 0); settle;
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] v, c1, c2;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); chk("R1 reset reg", v, 0);
    end
    chk("R1 irq", W'(irq), 0);
    chk("R1 pending", W'(wr_pending), 0);

    wr(A_LOAD, 32'hA5A5);
    chk("R8 pending j0", W'(wr_pending), 1);
    rd(A_LOAD, v); chk("R8 old j0", v, 0);
    @(negedge clk);
    chk("R8 pending j1", W'(wr_pending), 1);
    rd(A_LOAD, v); chk("R8 old j1", v, 0);
    @(negedge clk);
    chk("R8 pending j2", W'(wr_pending), 0);
    rd(A_LOAD, v); chk("R8 applied", v, 32'hA5A5);

    interval(4, 0, 0);
    chk("R7 irq gated off", W'(irq), 0);
    wr(A_IEN, 1); settle;
    chk("R7 irq on", W'(irq), 1);
    wr(A_STAT, 0); settle;
    rd(A_STAT, v); chk("R6 write zero ignored", v, 1);
    wr(A_STAT, 1); settle;
    rd(A_STAT, v); chk("R6 cleared", v, 0);
    chk("R7 irq drops", W'(irq), 0);

    interval(3, 1, 1);

    wr(A_CTRL, 2); settle;
    wr(A_LSTART, 32'h100); settle;
    rd(A_CTRL, v); chk("R9 keeps reload", v, 3);
    rd(A_COUNT, c1);
    @(negedge clk);
    rd(A_COUNT, c2); chk("R10 read no disturb", c2, c1 + 1);
    wr(A_LOAD, 32'h7); settle;
    rd(A_COUNT, v); chk("R9 load write keeps count", v, c1 + 5);
    rd(A_CTRL, v); chk("R9 load write keeps run", v, 3);
    wr(A_CTRL, 2); settle;
    rd(A_COUNT, c1);
    repeat (5) @(negedge clk);
    rd(A_COUNT, v); chk("R2 stopped holds", v, c1);
    wr(A_COUNT, 32'h55); settle;
    rd(A_COUNT, v); chk("R2 counter write", v, 32'h55);

    for (int k = 0; k < 8; k++) begin
      int n = 3 + int'($urandom_range(40));
      bit p = 1'($urandom_range(1));
      interval(n, p, 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule